// File: doc/BRIEF.md
# Command-Word Register Bridge

This block sits between a host bus and the small byte-wide register file of a two-wire serial controller. The host sees one 64-bit command word. To reach an internal register, the host writes that word with its top bit set. The write also carries an opcode, an extended selector, a direction flag and a data byte. The bridge decodes the word and drives one strobe on the internal register port. It then clears the top bit, which tells the host that the access is done. On a read, the byte returned by the internal register replaces the low byte of the command word.

The serial protocol engine is outside this block. It attaches through a plain port: a write strobe, a read strobe, a reset strobe, a register selector, write data, and read data that answers the selector in the same cycle. A host that polls the command word until the top bit drops has finished a complete register access. The bridge holds the busy state for a parameterised number of cycles before it performs the access. Host writes that arrive while the bridge is busy are dropped.

Top module: `cmdwin_bridge`

## Requirements
- R1: After reset the command word reads all zeros and none of the three engine strobes is asserted.
- R2: A host write whose bit 63 is 1, made while bit 63 of the stored word is 0, stores the whole word. Bit 63 then reads 1 for HOLD+1 cycles. The single engine strobe falls in the last of those cycles, and bit 63 reads 0 from the next cycle on.
- R3: Bits 60:57 are the opcode, bits 34:32 the extended selector, and bit 56 the direction flag (1 means read). Opcode 4 reaches the clock high-period register (engine selector 4). Opcode 6 with extended selector 1 reaches the data register (engine selector 0), and opcode 6 with extended selector 2 reaches the control register (engine selector 1).
- R4: With opcode 6 and extended selector 3, a write goes to the clock-control register (engine selector 2) and a read goes to the status register (engine selector 3).
- R5: A read access pulses the read strobe. When the access completes, bits 7:0 of the word hold the byte the engine returned in the strobe cycle, and bits 62:8 are unchanged.
- R6: A write access pulses the write strobe with bits 7:0 of the stored word on the write-data output. The stored word keeps that byte.
- R7: Opcode 6 with extended selector 7 pulses the reset strobe and neither the read nor the write strobe, whatever the direction flag says. If the direction flag is set, bits 7:0 read back as 0x00.
- R8: A host write that arrives while bit 63 of the stored word is 1, including in the cycle in which the access completes, is ignored. Bits 62:8 never change while the bridge is busy.
- R9: Any other opcode or extended selector completes like a normal access but asserts no strobe. A read of this kind returns 0x00 in bits 7:0; a write of this kind leaves the word as written, with bit 63 cleared.
- R10: A host write with bit 63 equal to 0, made while the bridge is idle, stores the word as given and starts no access.
- R11: At most one engine strobe is asserted in any cycle, and a strobe is only asserted while bit 63 of the stored word is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command word as the host reads it |
| eng_wr | output | 1 | Internal register write strobe |
| eng_rd | output | 1 | Internal register read strobe |
| eng_rst | output | 1 | Protocol engine soft-reset strobe |
| eng_sel | output | 3 | Internal register selector |
| eng_wdata | output | 8 | Byte to write into the selected register |
| eng_rdata | input | 8 | Byte returned by the selected register in the same cycle |

## Verification
Two things can fall on the same clock edge: a new host write, and the completion of the access in progress, which clears bit 63. The bench provokes this by keeping the host write strobe high, with a different word, through the whole busy window, including the completion edge. The scoreboard must then see exactly one engine strobe, and the word read back afterwards must be the first command with its result, with no trace of the second word. A second collision is a new command issued right after a completion. This shows that the bridge accepts a write on the first edge after it becomes idle.

// File: rtl/cmdwin_bridge.sv
module cmdwin_bridge #(
  parameter int HOLD = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [63:0] host_wdata,
  output logic [63:0] host_rdata,
  output logic        eng_wr,
  output logic        eng_rd,
  output logic        eng_rst,
  output logic [2:0]  eng_sel,
  output logic [7:0]  eng_wdata,
  input  logic [7:0]  eng_rdata
);

  localparam int CW = (HOLD < 1) ? 1 : $clog2(HOLD + 1);
  localparam int VLD_BIT = 63;
  localparam int DIR_BIT = 56;
  localparam logic [3:0] OP_HIGHP = 4'd4;
  localparam logic [3:0] OP_EXT   = 4'd6;

  logic [63:0]   word;
  logic [CW-1:0] hold_cnt;
  logic          busy, go, is_rd, sel_ok, is_rst;
  logic [3:0]    op;
  logic [2:0]    sub, sel;

  assign busy  = word[VLD_BIT];
  assign go    = busy && (hold_cnt == '0);
  assign op    = word[60:57];
  assign sub   = word[34:32];
  assign is_rd = word[DIR_BIT];

  always_comb begin
    sel_ok = 1'b0;
    is_rst = 1'b0;
    sel    = 3'd0;
    if (op == OP_HIGHP) begin
      sel_ok = 1'b1;
      sel    = 3'd4;
    end else if (op == OP_EXT) begin
      case (sub)
        3'd1: begin sel_ok = 1'b1; sel = 3'd0; end
        3'd2: begin sel_ok = 1'b1; sel = 3'd1; end
        3'd3: begin sel_ok = 1'b1; sel = is_rd ? 3'd3 : 3'd2; end
        3'd7: is_rst = 1'b1;
        default: ;
      endcase
    end
  end

  assign eng_wr     = go && sel_ok && !is_rd;
  assign eng_rd     = go && sel_ok && is_rd;
  assign eng_rst    = go && is_rst;
  assign eng_sel    = sel;
  assign eng_wdata  = word[7:0];
  assign host_rdata = word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word     <= '0;
      hold_cnt <= '0;
    end else if (go) begin
      word[VLD_BIT] <= 1'b0;
      if (is_rd) word[7:0] <= eng_rd ? eng_rdata : 8'h00;
    end else if (busy) begin
      hold_cnt <= hold_cnt - 1'b1;
    end else if (host_wr) begin
      word     <= host_wdata;
      hold_cnt <= CW'(HOLD);
    end
  end

endmodule

module cmdwin_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] host_rdata,
  input logic        eng_wr,
  input logic        eng_rd,
  input logic        eng_rst,
  input logic [7:0]  eng_rdata
);

  logic any_stb;
  assign any_stb = eng_wr | eng_rd | eng_rst;

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_wr, eng_rd, eng_rst}));

  assert_strobe_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> host_rdata[63]);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |=> !host_rdata[63]);

  assert_read_returned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rd |=> host_rdata[7:0] == $past(eng_rdata));

  assert_busy_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[63] |=> host_rdata[62:8] == $past(host_rdata[62:8]));

endmodule

bind cmdwin_bridge cmdwin_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_rdata(host_rdata),
  .eng_wr(eng_wr), .eng_rd(eng_rd), .eng_rst(eng_rst), .eng_rdata(eng_rdata)
);

// File: tb/test_cmdwin_bridge.sv
`timescale 1ns/1ps
module test_cmdwin_bridge;
  localparam int HOLD = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        eng_wr, eng_rd, eng_rst;
  logic [2:0]  eng_sel;
  logic [7:0]  eng_wdata;
  logic [7:0]  eng_rdata;

  always #2 clk = ~clk;

  cmdwin_bridge #(.HOLD(HOLD)) i_cmdwin_bridge (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .eng_wr(eng_wr), .eng_rd(eng_rd), .eng_rst(eng_rst),
    .eng_sel(eng_sel), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
  );

  // engine register file model
  logic [7:0] m_reg [0:4];
  logic [7:0] m_stat;
  always_comb begin
    if (eng_sel == 3'd3) eng_rdata = m_stat;
    else if (eng_sel <= 3'd4) eng_rdata = m_reg[eng_sel];
    else eng_rdata = 8'h00;
  end
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_reg[i] <= 8'h00;
      m_stat <= 8'h08;
    end else if (eng_rst) begin
      m_stat   <= 8'hF8;
      m_reg[1] <= 8'h00;
    end else if (eng_wr && eng_sel != 3'd3) begin
      m_reg[eng_sel] <= eng_wdata;
    end
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // expected strobe items: {kind[1:0], sel[2:0], byte[7:0]}; kind 0 wr, 1 rd, 2 rst
  logic [12:0] exp_q [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expectations as strobes appear
  always @(negedge clk) begin
    if (rst_n && (eng_wr | eng_rd | eng_rst)) begin
      logic [1:0] k;
      k = eng_wr ? 2'd0 : (eng_rd ? 2'd1 : 2'd2);
      if (exp_q.size() == 0) begin
        check(1'b0, "R9/R8 unexpected strobe", {59'd0, k, eng_sel}, 64'd0);
      end else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        if (e[12:11] == 2'd2)
          check(k == 2'd2, "R7 reset strobe kind", k, e[12:11]);
        else if (e[12:11] == 2'd1)
          check(k == 2'd1 && eng_sel == e[10:8], "R3/R4 read strobe",
                {k, eng_sel}, e[12:8]);
        else
          check(k == 2'd0 && eng_sel == e[10:8] && eng_wdata == e[7:0],
                "R3/R6 write strobe", {k, eng_sel, eng_wdata}, e);
      end
    end
  end

  function automatic logic [63:0] mk(input logic [3:0] op, input logic [2:0] sub,
                                     input bit rd, input logic [7:0] b);
    logic [63:0] w;
    w = 64'd0;
    w[63] = 1'b1;
    w[60:57] = op;
    w[56] = rd;
    w[47:40] = 8'hA5;
    w[34:32] = sub;
    w[7:0] = b;
    return w;
  endfunction

  // driver: issue one command and check the handshake and the returned word
  task automatic cmd(input logic [63:0] w, input bit has_item, input logic [12:0] item,
                     input logic [7:0] rbyte, input string req);
    logic [63:0] expw;
    if (has_item) exp_q.push_back(item);
    expw = w;
    expw[63] = 1'b0;
    if (w[56]) expw[7:0] = rbyte;
    host_wdata = w;
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    check(host_rdata[63] == 1'b1, {req, " R2 valid set"}, host_rdata[63], 1);
    repeat (HOLD + 1) @(negedge clk);
    check(host_rdata == expw, {req, " R2 done word"}, host_rdata, expw);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(host_rdata == 64'd0, "R1 reset word", host_rdata, 0);
    check(!(eng_wr | eng_rd | eng_rst), "R1 no strobe", {eng_wr, eng_rd, eng_rst}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cmd(mk(6, 1, 0, 8'h3C), 1, {2'd0, 3'd0, 8'h3C}, 8'h00, "R3 R6 data write");
    cmd(mk(6, 1, 1, 8'hFF), 1, {2'd1, 3'd0, 8'h00}, 8'h3C, "R5 data read");
    cmd(mk(6, 2, 0, 8'h44), 1, {2'd0, 3'd1, 8'h44}, 8'h00, "R3 ctrl write");
    cmd(mk(6, 2, 1, 8'h00), 1, {2'd1, 3'd1, 8'h00}, 8'h44, "R5 ctrl read");
    cmd(mk(4, 0, 0, 8'h18), 1, {2'd0, 3'd4, 8'h18}, 8'h00, "R3 high-period write");
    cmd(mk(4, 0, 1, 8'h00), 1, {2'd1, 3'd4, 8'h00}, 8'h18, "R3 high-period read");
    cmd(mk(6, 3, 0, 8'h13), 1, {2'd0, 3'd2, 8'h13}, 8'h00, "R4 clkctl write");
    cmd(mk(6, 3, 1, 8'h00), 1, {2'd1, 3'd3, 8'h00}, 8'h08, "R4 status read");
    cmd(mk(6, 7, 0, 8'h5A), 1, {2'd2, 3'd0, 8'h00}, 8'h00, "R7 soft reset");
    cmd(mk(6, 3, 1, 8'h00), 1, {2'd1, 3'd3, 8'h00}, 8'hF8, "R7 status after reset");
    cmd(mk(6, 7, 1, 8'h99), 1, {2'd2, 3'd0, 8'h00}, 8'h00, "R7 reset with read flag");
    cmd(mk(2, 1, 1, 8'h77), 0, 13'd0, 8'h00, "R9 unused opcode read");
    cmd(mk(6, 5, 0, 8'h66), 0, 13'd0, 8'h00, "R9 unused selector write");
    cmd(mk(6, 0, 1, 8'h55), 0, 13'd0, 8'h00, "R9 unused selector read");

    // R10: write with valid clear
    host_wdata = 64'h1234_5678_9ABC_DEF0 & ~(64'd1 << 63);
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    repeat (3) @(negedge clk);
    check(host_rdata == (64'h1234_5678_9ABC_DEF0 & ~(64'd1 << 63)), "R10 plain store",
          host_rdata, 64'h1234_5678_9ABC_DEF0 & ~(64'd1 << 63));

    // R8: keep writing a different word through the busy window and the completion edge
    exp_q.push_back({2'd0, 3'd0, 8'hC3});
    host_wdata = mk(6, 1, 0, 8'hC3);
    host_wr = 1'b1;
    @(negedge clk);
    host_wdata = mk(6, 2, 0, 8'hEE) ^ 64'h00FF_0000_0000_0000;
    repeat (HOLD + 1) @(negedge clk);
    host_wr = 1'b0;
    begin
      logic [63:0] e;
      e = mk(6, 1, 0, 8'hC3);
      e[63] = 1'b0;
      check(host_rdata == e, "R8 busy write ignored", host_rdata, e);
    end
    // data register must still hold the first byte, not the dropped one
    cmd(mk(6, 1, 1, 8'h00), 1, {2'd1, 3'd0, 8'h00}, 8'hC3, "R8 data after busy write");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all strobes seen", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule